// File: doc/BRIEF.md
# Codec Link Global Control and Status

This block holds the global control word and the global status word of a serial codec link controller. The control word drives three link pins: an active-low cold reset, a warm reset, and a link shut-off. The warm reset clears itself after a fixed number of cycles. The status word gathers several kinds of information:

- codec-ready indications for up to three codecs;
- resume and general-purpose-input events from those codecs;
- a codec read timeout;
- two power-down semaphores;
- three bits mirrored from codec slot 12;
- the live interrupt lines of the modem capture and modem playback DMA channels.

All of these are folded into a single interrupt output.

Software reaches both words through a plain register port. Reads are combinational and have no side effects. A write takes effect on the clock edge where `bus_we` is high. The control word sits at offset 0x3C and the status word at offset 0x40. Any other offset reads as zero and ignores writes.

Codec-ready, resume, general-purpose-input and slot 12 inputs come from the link clock domain. Each passes through a synchronizer of `SYNC_STAGES` flops. The read timeout pulse and the channel interrupt lines are synchronous to `clk`. The serial framing of the link and the DMA engines sit outside this block.

Top module: `codec_link_gctl`

## Requirements
- R1: The control word is decoded at offset 0x3C and the status word at 0x40. Every other offset reads 0, and a write to it changes no state.
- R2: After reset the control word reads 0, so `link_cold_n` is low and the link is held in cold reset. The status word reads 0 apart from its live bits.
- R3: Control bit 1 is the active-low cold reset. `link_cold_n` follows the stored bit, and writing 1 releases the link.
- R4: Writing 1 to control bit 2 starts a warm reset under three conditions: the cold bit was already 1, the same write keeps the cold bit at 1, and the same write leaves bit 3 at 0. The bit then reads 1 and drives `link_warm` for exactly `WARM_CYCLES` cycles, then clears itself. A write that clears bit 1 or sets bit 3 cancels a warm reset in progress. Writing 0 to bit 2 has no effect.
- R5: Control bit 3 is the link shut-off and drives `link_off`. While it is set, the warm reset is held at 0 and all codec-ready bits are held at 0.
- R6: Status bits 8, 9 and 28 are the ready bits of codecs 0, 1 and 2. A ready bit sets `SYNC_STAGES+1` edges after its input rises and stays set after the input falls, until the link is shut off.
- R7: Status bits 10, 11 and 29 hold resume events of codecs 0, 1 and 2, and bit 0 holds the general-purpose-input change. These bits are sticky and clear when 1 is written to them. A set in the same cycle wins over the clear.
- R8: Status bit 15 is set by a `rd_timeout` pulse and clears when 1 is written to it.
- R9: `irq` is the OR of four terms:
  - status bits 1 and 2;
  - status bit 0 gated by control bit 0;
  - each of resume bits 10, 11 and 29 gated by its enable, which is control bit 4, 5 or 6 respectively.
- R10: Status bits 1 and 2 show `mdm_in_irq` and `mdm_out_irq` in the same cycle. Status bits 14:12 show `slot12_bits` after `SYNC_STAGES` edges.
- R11: Status bits 17:16 are two semaphore bits that software reads and writes directly.
- R12: Control bits 0 and 6:4 are plain read/write bits. Control bits 31:7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| codec_rdy | input | 3 | Codec ready inputs, asynchronous |
| resume_evt | input | 3 | Codec resume events, asynchronous |
| gpi_chg | input | 1 | General-purpose-input change event, asynchronous |
| rd_timeout | input | 1 | Codec read timeout pulse, synchronous |
| mdm_in_irq | input | 1 | Modem capture channel interrupt line |
| mdm_out_irq | input | 1 | Modem playback channel interrupt line |
| slot12_bits | input | 3 | Slot 12 status bits, asynchronous |
| link_cold_n | output | 1 | Link cold reset, active low |
| link_warm | output | 1 | Link warm reset |
| link_off | output | 1 | Link shut-off |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with `WARM_CYCLES` set to 5 and `SYNC_STAGES` set to 2. At 5 cycles, the full self-clearing warm pulse, and a cancel in the middle of one, fit inside a few register writes. At 2 stages, the synchronizer delay is short enough that a resume event and a clearing write arriving close together can be placed in the same cycle, which makes set-beats-clear observable. The bench's reference model follows the same pipeline depths, so every ready, resume and slot 12 bit is compared cycle by cycle at the exact edge where it should appear.

// File: rtl/gctl_pkg.sv
package gctl_pkg;
  localparam int REG_W     = 32;
  localparam int NUM_CODEC = 3;
  localparam int SLOT_W    = 3;

  // control word bit positions
  localparam int C_GIE  = 0;
  localparam int C_COLD = 1;
  localparam int C_WARM = 2;
  localparam int C_OFF  = 3;
  localparam int C_RSM  = 4;

  // status word bit positions
  localparam int S_GPI    = 0;
  localparam int S_CH_IN  = 1;
  localparam int S_CH_OUT = 2;
  localparam int S_SLOT   = 12;
  localparam int S_TMO    = 15;
  localparam int S_SEM    = 16;

  typedef struct packed {
    logic [NUM_CODEC-1:0] rsm_en;
    logic                 off;
    logic                 warm;
    logic                 cold_n;
    logic                 gie;
  } gctl_ctl_t;

  function automatic int rdy_bit(input int idx);
    case (idx)
      0:       return 8;
      1:       return 9;
      default: return 28;
    endcase
  endfunction

  function automatic int rsm_bit(input int idx);
    case (idx)
      0:       return 10;
      1:       return 11;
      default: return 29;
    endcase
  endfunction
endpackage

// File: rtl/gctl_sync.sv
module gctl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [W-1:0] stage_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign q_o = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/gctl_sticky.sv
module gctl_sticky #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] bits_q;

  // a set arriving with a clear in the same cycle keeps the bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= (bits_q & ~clr_i) | set_i;
  end

  assign q_o = bits_q;
endmodule

// File: rtl/gctl_ctlreg.sv
module gctl_ctlreg
  import gctl_pkg::*;
#(
  parameter int WARM_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output gctl_ctl_t        ctl_o
);
  localparam int CNT_W = (WARM_CYCLES > 1) ? $clog2(WARM_CYCLES) : 1;

  gctl_ctl_t        ctl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             warm_start;
  logic             warm_kill;

  assign warm_start = wr_i & wdata_i[C_WARM] & wdata_i[C_COLD] &
                      ~wdata_i[C_OFF] & ctl_q.cold_n;
  assign warm_kill  = wr_i & (~wdata_i[C_COLD] | wdata_i[C_OFF]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_i) begin
        ctl_q.gie    <= wdata_i[C_GIE];
        ctl_q.cold_n <= wdata_i[C_COLD];
        ctl_q.off    <= wdata_i[C_OFF];
        ctl_q.rsm_en <= wdata_i[C_RSM +: NUM_CODEC];
      end
      if (warm_start) begin
        ctl_q.warm <= 1'b1;
        cnt_q      <= CNT_W'(WARM_CYCLES - 1);
      end else if (warm_kill) begin
        ctl_q.warm <= 1'b0;
      end else if (ctl_q.warm) begin
        if (cnt_q == '0) ctl_q.warm <= 1'b0;
        else             cnt_q      <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/codec_link_gctl.sv
module codec_link_gctl
  import gctl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int CTL_ADDR    = 'h3C,
  parameter int STA_ADDR    = 'h40,
  parameter int WARM_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  input  logic [NUM_CODEC-1:0] codec_rdy,
  input  logic [NUM_CODEC-1:0] resume_evt,
  input  logic                 gpi_chg,
  input  logic                 rd_timeout,
  input  logic                 mdm_in_irq,
  input  logic                 mdm_out_irq,
  input  logic [SLOT_W-1:0]    slot12_bits,
  output logic                 link_cold_n,
  output logic                 link_warm,
  output logic                 link_off,
  output logic                 irq
);
  localparam int ASYNC_W = 2 * NUM_CODEC + 1 + SLOT_W;
  localparam int EVT_W   = NUM_CODEC + 1;

  logic                 ctl_hit, sta_hit, ctl_wr, sta_wr;
  gctl_ctl_t            ctl;
  logic [ASYNC_W-1:0]   async_vec, sync_vec;
  logic [NUM_CODEC-1:0] rdy_s, rsm_s, rdy_q;
  logic                 gpi_s;
  logic [SLOT_W-1:0]    slot_s;
  logic [EVT_W-1:0]     evt_set, evt_clr, evt_q;
  logic                 tmo_q;
  logic [1:0]           sem_q;
  logic [REG_W-1:0]     status_w;
  logic                 gie_w, gpi_pend;

  assign ctl_hit = (bus_addr == ADDR_W'(CTL_ADDR));
  assign sta_hit = (bus_addr == ADDR_W'(STA_ADDR));
  assign ctl_wr  = bus_we & ctl_hit;
  assign sta_wr  = bus_we & sta_hit;

  gctl_ctlreg #(.WARM_CYCLES(WARM_CYCLES)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (ctl_wr),
    .wdata_i (bus_wdata),
    .ctl_o   (ctl)
  );

  assign async_vec = {slot12_bits, gpi_chg, resume_evt, codec_rdy};

  gctl_sync #(.W(ASYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (async_vec),
    .q_o   (sync_vec)
  );

  assign rdy_s  = sync_vec[NUM_CODEC-1:0];
  assign rsm_s  = sync_vec[2*NUM_CODEC-1:NUM_CODEC];
  assign gpi_s  = sync_vec[2*NUM_CODEC];
  assign slot_s = sync_vec[ASYNC_W-1 -: SLOT_W];

  // codec ready: sticky, flushed and blocked while the link is shut off
  gctl_sticky #(.W(NUM_CODEC)) u_rdy (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (rdy_s & {NUM_CODEC{~ctl.off}}),
    .clr_i ({NUM_CODEC{ctl.off}}),
    .q_o   (rdy_q)
  );

  // resume and GPI events: sticky, write-1-to-clear
  assign evt_set = {gpi_s, rsm_s};
  generate
    for (genvar i = 0; i < NUM_CODEC; i++) begin : g_evt_clr
      assign evt_clr[i] = sta_wr & bus_wdata[rsm_bit(i)];
    end
  endgenerate
  assign evt_clr[NUM_CODEC] = sta_wr & bus_wdata[S_GPI];

  gctl_sticky #(.W(EVT_W)) u_evt (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt_set),
    .clr_i (evt_clr),
    .q_o   (evt_q)
  );

  gctl_sticky #(.W(1)) u_tmo (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (rd_timeout),
    .clr_i (sta_wr & bus_wdata[S_TMO]),
    .q_o   (tmo_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sem_q <= '0;
    else if (sta_wr) sem_q <= bus_wdata[S_SEM +: 2];
  end

  always_comb begin
    status_w                 = '0;
    status_w[S_GPI]          = evt_q[NUM_CODEC];
    status_w[S_CH_IN]        = mdm_in_irq;
    status_w[S_CH_OUT]       = mdm_out_irq;
    status_w[S_SLOT +: SLOT_W] = slot_s;
    status_w[S_TMO]          = tmo_q;
    status_w[S_SEM +: 2]     = sem_q;
    for (int i = 0; i < NUM_CODEC; i++) begin
      status_w[rdy_bit(i)] = rdy_q[i];
      status_w[rsm_bit(i)] = evt_q[i];
    end
  end

  always_comb begin
    if (ctl_hit)      bus_rdata = REG_W'(ctl);
    else if (sta_hit) bus_rdata = status_w;
    else              bus_rdata = '0;
  end

  assign gie_w    = ctl.gie;
  assign gpi_pend = evt_q[NUM_CODEC];

  assign irq = mdm_in_irq | mdm_out_irq | (gpi_pend & gie_w) |
               (|(evt_q[NUM_CODEC-1:0] & ctl.rsm_en));

  assign link_cold_n = ctl.cold_n;
  assign link_warm   = ctl.warm;
  assign link_off    = ctl.off;
endmodule

// File: rtl/gctl_chk.sv
module gctl_chk
  import gctl_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 link_cold_n,
  input logic                 link_warm,
  input logic                 link_off,
  input logic                 irq,
  input logic                 mdm_in_irq,
  input logic                 mdm_out_irq,
  input logic                 gpi_pend,
  input logic                 gie_w,
  input logic [NUM_CODEC-1:0] rdy_q
);
  p_warm_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    link_warm |-> link_cold_n);

  p_off_no_warm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    link_off |-> !link_warm);

  p_off_flush_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    link_off |=> (rdy_q == '0));

  p_gpi_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gpi_pend && gie_w) |-> irq);

  p_chan_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mdm_in_irq || mdm_out_irq) |-> irq);
endmodule

bind codec_link_gctl gctl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .link_cold_n (link_cold_n),
  .link_warm   (link_warm),
  .link_off    (link_off),
  .irq         (irq),
  .mdm_in_irq  (mdm_in_irq),
  .mdm_out_irq (mdm_out_irq),
  .gpi_pend    (gpi_pend),
  .gie_w       (gie_w),
  .rdy_q       (rdy_q)
);

// File: tb/codec_link_gctl_test.sv
`timescale 1ns/1ps
module codec_link_gctl_test;
  localparam int WARM = 5;
  localparam int SYNC = 2;
  localparam logic [7:0] A_CTL = 8'h3C;
  localparam logic [7:0] A_STA = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  codec_rdy = '0, resume_evt = '0, slot12_bits = '0;
  logic        gpi_chg = 1'b0, rd_timeout = 1'b0, mdm_in_irq = 1'b0, mdm_out_irq = 1'b0;
  logic        link_cold_n, link_warm, link_off, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit started  = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  codec_link_gctl #(.WARM_CYCLES(WARM), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .codec_rdy(codec_rdy),
    .resume_evt(resume_evt), .gpi_chg(gpi_chg), .rd_timeout(rd_timeout),
    .mdm_in_irq(mdm_in_irq), .mdm_out_irq(mdm_out_irq), .slot12_bits(slot12_bits),
    .link_cold_n(link_cold_n), .link_warm(link_warm), .link_off(link_off), .irq(irq));

  // ---------------- behavioural reference model ----------------
  bit m_gie, m_cold, m_warm, m_off;
  bit [2:0] m_en, m_rdy;
  bit [3:0] m_evt;
  bit m_tmo;
  bit [1:0] m_sem;
  int m_cnt;
  logic [9:0] m_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gie = 0; m_cold = 0; m_warm = 0; m_off = 0; m_en = 0; m_rdy = 0;
      m_evt = 0; m_tmo = 0; m_sem = 0; m_cnt = 0;
      m_q.delete();
      for (int i = 0; i < SYNC; i++) m_q.push_back(10'b0);
    end else begin
      logic [9:0] s;
      bit cw, sw, start, kill;
      bit [3:0] clr;
      s  = m_q[0];
      cw = bus_we && bus_addr == A_CTL;
      sw = bus_we && bus_addr == A_STA;
      m_rdy = m_off ? 3'b000 : (m_rdy | s[2:0]);
      clr = sw ? {bus_wdata[0], bus_wdata[29], bus_wdata[11], bus_wdata[10]} : 4'b0;
      m_evt = (m_evt & ~clr) | {s[6], s[5:3]};
      m_tmo = (m_tmo & !(sw && bus_wdata[15])) | rd_timeout;
      if (sw) m_sem = bus_wdata[17:16];
      start = cw && bus_wdata[2] && bus_wdata[1] && !bus_wdata[3] && m_cold;
      kill  = cw && (!bus_wdata[1] || bus_wdata[3]);
      if (start) begin m_warm = 1; m_cnt = WARM - 1; end
      else if (kill) m_warm = 0;
      else if (m_warm) begin
        if (m_cnt == 0) m_warm = 0; else m_cnt--;
      end
      if (cw) begin
        m_gie = bus_wdata[0]; m_cold = bus_wdata[1]; m_off = bus_wdata[3]; m_en = bus_wdata[6:4];
      end
      void'(m_q.pop_front());
      m_q.push_back({slot12_bits, gpi_chg, resume_evt, codec_rdy});
    end
  end

  function automatic logic [31:0] exp_status();
    logic [31:0] st = '0;
    st[0] = m_evt[3]; st[1] = mdm_in_irq; st[2] = mdm_out_irq;
    st[8] = m_rdy[0]; st[9] = m_rdy[1]; st[28] = m_rdy[2];
    st[10] = m_evt[0]; st[11] = m_evt[1]; st[29] = m_evt[2];
    st[14:12] = m_q[0][9:7]; st[15] = m_tmo; st[17:16] = m_sem;
    return st;
  endfunction

  function automatic logic [31:0] exp_rdata();
    if (bus_addr == A_CTL) return {25'b0, m_en, m_off, m_warm, m_cold, m_gie};
    if (bus_addr == A_STA) return exp_status();
    return 32'b0;
  endfunction

  function automatic string rd_tag(logic [31:0] diff);
    int b = 0;
    while (b < 31 && !diff[b]) b++;
    if (bus_addr == A_CTL) begin
      if (b == 1) return "R3";
      if (b == 2) return "R4";
      if (b == 3) return "R5";
      return "R12";
    end
    if (bus_addr != A_STA) return "R1";
    if (b == 0 || b == 10 || b == 11 || b == 29) return "R7";
    if (b == 8 || b == 9 || b == 28) return "R6";
    if (b == 1 || b == 2 || (b >= 12 && b <= 14)) return "R10";
    if (b == 15) return "R8";
    if (b == 16 || b == 17) return "R11";
    return "R1";
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      logic [31:0] er;
      er = exp_rdata();
      chk(rd_tag(bus_rdata ^ er), bus_rdata, er);
      chk("R3", 32'(link_cold_n), 32'(m_cold));
      chk("R4", 32'(link_warm), 32'(m_warm));
      chk("R5", 32'(link_off), 32'(m_off));
      chk("R9", 32'(irq), 32'(mdm_in_irq | mdm_out_irq | (m_evt[3] & m_gie) | (|(m_evt[2:0] & m_en))));
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    step();
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    started = 1;
    bus_addr = A_CTL; step(2);
    chk("R2", bus_rdata, 32'h0);
    chk("R2", 32'(link_cold_n), 32'h0);
    bus_addr = A_STA; step();
    chk("R2", bus_rdata, 32'h0);

    // warm ignored while cold reset asserted
    wr(A_CTL, 32'h4); step();
    chk("R4", 32'(link_warm), 32'h0);
    // release, then warm pulse of WARM cycles
    wr(A_CTL, 32'h2);
    chk("R3", 32'(link_cold_n), 32'h1);
    wr(A_CTL, 32'h6);
    begin
      int n = 0;
      while (link_warm && n < 100) begin n++; step(); end
      chk("R4", 32'(n), 32'(WARM));
    end

    // codec ready sticky
    codec_rdy = 3'b101; step(4);
    bus_addr = A_STA; step();
    chk("R6", {bus_rdata[28], bus_rdata[9], bus_rdata[8]}, 32'h5);
    codec_rdy = 3'b000; step(4);
    chk("R6", {bus_rdata[28], bus_rdata[9], bus_rdata[8]}, 32'h5);

    // resume / GPI events and interrupt gating
    wr(A_CTL, 32'h73);
    resume_evt = 3'b011; gpi_chg = 1; step();
    resume_evt = 3'b000; gpi_chg = 0; step(4);
    bus_addr = A_STA; step();
    chk("R7", {bus_rdata[11], bus_rdata[10], bus_rdata[0]}, 32'h7);
    chk("R9", 32'(irq), 32'h1);
    wr(A_STA, 32'h400); step();
    chk("R7", {bus_rdata[11], bus_rdata[10]}, 32'h2);
    wr(A_STA, 32'h801); step();
    chk("R9", 32'(irq), 32'h0);
    wr(A_CTL, 32'h2);
    resume_evt = 3'b100; step(); resume_evt = 3'b000; step(4);
    bus_addr = A_STA; step();
    chk("R7", 32'(bus_rdata[29]), 32'h1);
    chk("R9", 32'(irq), 32'h0);
    wr(A_STA, 32'h2000_0000);

    // read timeout
    rd_timeout = 1; step(); rd_timeout = 0; step();
    chk("R8", 32'(bus_rdata[15]), 32'h1);
    wr(A_STA, 32'h8000); step();
    chk("R8", 32'(bus_rdata[15]), 32'h0);

    // live channel lines and slot 12 mirror
    mdm_in_irq = 1; step();
    chk("R10", {bus_rdata[2:1], 31'(irq)}, {2'b01, 31'h1});
    mdm_in_irq = 0; mdm_out_irq = 1; slot12_bits = 3'b110; step(3);
    chk("R10", 32'(bus_rdata[14:12]), 32'h6);
    chk("R10", 32'(bus_rdata[2]), 32'h1);
    mdm_out_irq = 0; step();

    // semaphores
    wr(A_STA, 32'h3_0000); step();
    chk("R11", 32'(bus_rdata[17:16]), 32'h3);
    wr(A_STA, 32'h0); step();
    chk("R11", 32'(bus_rdata[17:16]), 32'h0);

    // unmapped offset
    wr(8'h44, 32'hFFFF_FFFF);
    chk("R1", bus_rdata, 32'h0);
    bus_addr = A_CTL; step();
    chk("R1", bus_rdata, 32'h2);

    // shut-off flushes ready and blocks warm
    codec_rdy = 3'b011; step(4);
    wr(A_CTL, 32'hA); step(2);
    chk("R5", 32'(link_off), 32'h1);
    bus_addr = A_STA; step();
    chk("R5", {bus_rdata[28], bus_rdata[9], bus_rdata[8]}, 32'h0);
    wr(A_CTL, 32'hE); step();
    chk("R5", 32'(link_warm), 32'h0);
    wr(A_CTL, 32'h2); step(4);
    bus_addr = A_STA; step();
    chk("R6", {bus_rdata[28], bus_rdata[9], bus_rdata[8]}, 32'h3);

    // set wins over write-1-to-clear
    resume_evt = 3'b001; step(4);
    wr(A_STA, 32'h400); step();
    chk("R7", 32'(bus_rdata[10]), 32'h1);
    resume_evt = 3'b000; step(3);
    wr(A_STA, 32'h400); step();
    chk("R7", 32'(bus_rdata[10]), 32'h0);

    // warm reset cancelled by asserting cold reset
    wr(A_CTL, 32'h6); step();
    wr(A_CTL, 32'h0);
    chk("R4", 32'(link_warm), 32'h0);
    chk("R3", 32'(link_cold_n), 32'h0);

    // plain enable bits, upper bits read zero
    wr(A_CTL, 32'hFFFF_FF71);
    bus_addr = A_CTL; step();
    chk("R12", bus_rdata, 32'h71);

    step(3);
    finish_run();
  end
endmodule